// File: doc/BRIEF.md
# Floating-Point Condition Code Unit

This block watches the results leaving a floating-point datapath and keeps four condition flags describing the most recent one: negative, zero, infinity and not-a-number. Each result is an 80-bit extended-precision value: a 16-bit word that holds the sign and the 15-bit exponent, and a 64-bit mantissa whose top bit is an explicit integer bit. When the result strobe is high, the four flags are cleared and reloaded from that value on the next clock edge. When the strobe is low, the flags hold.

A second, purely combinational path evaluates a 6-bit predicate code against the stored flags. It answers conditional branches, sets and traps. The predicates are IEEE-aware. The not-a-number flag makes the ordered forms (greater, less, and so on) false, and makes their unordered counterparts true. The fifth code bit is ignored, so codes 0x10 to 0x1F mirror codes 0x00 to 0x0F. Codes of 0x20 and above are reported as unsupported and evaluate false.

Top module: `fpcc_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all four flags.
- R2: With `res_valid` high at a clock edge, all four flags are replaced by the classification of `res_se`/`res_man`. With `res_valid` low, they keep their value.
- R3: The N flag takes bit 15 of `res_se`, whatever the class of the value.
- R4: The Z flag is set when `res_se[14:0]` is zero and `res_man[62:0]` is zero. Bit 63 of the mantissa has no effect on it.
- R5: The I flag is set when `res_se[14:0]` is 0x7FFF and `res_man[62:0]` is zero. Bit 63 of the mantissa has no effect on it.
- R6: The NaN flag is set when `res_se[14:0]` is 0x7FFF and `res_man[62:0]` is non-zero.
- R7: Predicate codes 0x10–0x1F give the same `pred_true` as the code with bit 4 cleared.
- R8: The ordered predicates are defined on the relations unordered (NaN), equal (Z), less (N, not Z, not NaN) and greater (not N, not Z, not NaN). Code 1 is equal. Code 2 is greater. Code 3 is greater or equal. Code 4 is less. Code 5 is less or equal. Code 6 is greater or less. Code 7 is ordered.
- R9: The unordered predicates use the same relations. Code 8 is unordered. Code 9 is unordered or equal. Code 0xA is unordered or greater. Code 0xB is unordered, greater or equal. Code 0xC is unordered or less. Code 0xD is unordered, less or equal. Code 0xE is not equal.
- R10: Code 0 always gives false, and code 0xF always gives true.
- R11: For a code of 0x20 or above, `pred_bad` is 1 and `pred_true` is 0. For codes below 0x20, `pred_bad` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| res_valid | input | 1 | Result strobe; loads the flags |
| res_se | input | 16 | Sign (bit 15) and exponent (bits 14:0) of the result |
| res_man | input | 64 | Mantissa with explicit integer bit 63 |
| pred_code | input | 6 | Predicate code to evaluate |
| cc_n | output | 1 | Stored negative flag |
| cc_z | output | 1 | Stored zero flag |
| cc_inf | output | 1 | Stored infinity flag |
| cc_nan | output | 1 | Stored not-a-number flag |
| pred_true | output | 1 | Predicate result on the stored flags |
| pred_bad | output | 1 | Predicate code not supported |

## Verification
The properties assume that `rst` is asserted at the first clock edge, so that the flags have a known value before any hold or follow property is sampled. They also assume that `res_valid` and the result inputs are defined whenever reset is low. The bench keeps to this by holding reset over the first edges. After that, it changes every input only on the falling clock edge, and it sets the strobe only for a single cycle around each result. The predicate code may take any of its 64 values without restriction, and the bench sweeps all of them after each loaded result.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

  typedef struct packed {
    logic n;
    logic z;
    logic inf;
    logic nan;
  } fpcc_flags_t;

  // Flags from the exponent field and mantissa; the mantissa's top bit is
  // shifted out so only the fraction is examined.
  function automatic fpcc_flags_t fpcc_classify(input logic sign,
                                                input logic exp_zero,
                                                input logic exp_max,
                                                input logic frac_zero);
    fpcc_flags_t f;
    f.n   = sign;
    f.z   = exp_zero & frac_zero;
    f.inf = exp_max & frac_zero;
    f.nan = exp_max & ~frac_zero;
    return f;
  endfunction

  // Low four bits of the predicate code against the stored flags.
  function automatic logic fpcc_test(input logic [3:0] sel,
                                     input fpcc_flags_t f);
    logic r;
    case (sel)
      4'h0: r = 1'b0;
      4'h1: r = f.z;
      4'h2: r = ~(f.nan | f.z | f.n);
      4'h3: r = f.z | ~(f.nan | f.n);
      4'h4: r = f.n & ~(f.nan | f.z);
      4'h5: r = f.z | (f.n & ~f.nan);
      4'h6: r = ~f.nan & ~f.z;
      4'h7: r = ~f.nan;
      4'h8: r = f.nan;
      4'h9: r = f.nan | f.z;
      4'hA: r = f.nan | ~(f.n | f.z);
      4'hB: r = f.nan | f.z | ~f.n;
      4'hC: r = f.nan | (f.n & ~f.z);
      4'hD: r = f.nan | f.z | f.n;
      4'hE: r = ~f.z;
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fpcc_classify.sv
module fpcc_classify #(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic [EXP_W:0]   se,
  input  logic [MAN_W-1:0] man,
  output fpcc_pkg::fpcc_flags_t flags,
  output logic             exp_zero,
  output logic             exp_max,
  output logic             frac_zero
);
  assign exp_zero  = (se[EXP_W-1:0] == '0);
  assign exp_max   = &se[EXP_W-1:0];
  assign frac_zero = ((man << 1) == '0);
  assign flags     = fpcc_pkg::fpcc_classify(se[EXP_W], exp_zero, exp_max, frac_zero);
endmodule

// File: rtl/fpcc_ccreg.sv
module fpcc_ccreg (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  fpcc_pkg::fpcc_flags_t d,
  output fpcc_pkg::fpcc_flags_t q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/fpcc_pred.sv
module fpcc_pred #(
  parameter int PRED_W = 6
) (
  input  logic [PRED_W-1:0] code,
  input  fpcc_pkg::fpcc_flags_t flags,
  output logic              hit,
  output logic              bad
);
  localparam int SEL_W = 4;
  localparam int ALIAS_BITS = 5;

  logic raw;

  generate
    if (PRED_W > ALIAS_BITS) begin : g_range
      assign bad = |code[PRED_W-1:ALIAS_BITS];
    end else begin : g_full
      assign bad = 1'b0;
    end
  endgenerate

  assign raw = fpcc_pkg::fpcc_test(code[SEL_W-1:0], flags);
  assign hit = raw & ~bad;
endmodule

// File: rtl/fpcc_unit.sv
module fpcc_unit #(
  parameter int EXP_W  = 15,
  parameter int MAN_W  = 64,
  parameter int PRED_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [EXP_W:0]    res_se,
  input  logic [MAN_W-1:0]  res_man,
  input  logic [PRED_W-1:0] pred_code,
  output logic              cc_n,
  output logic              cc_z,
  output logic              cc_inf,
  output logic              cc_nan,
  output logic              pred_true,
  output logic              pred_bad
);
  fpcc_pkg::fpcc_flags_t next_flags;
  fpcc_pkg::fpcc_flags_t cur_flags;
  logic exp_zero, exp_max, frac_zero;
  logic upd_fire;

  assign upd_fire = res_valid & ~rst;

  fpcc_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
    .se(res_se), .man(res_man), .flags(next_flags),
    .exp_zero(exp_zero), .exp_max(exp_max), .frac_zero(frac_zero)
  );

  fpcc_ccreg u_reg (
    .clk(clk), .rst(rst), .load(upd_fire), .d(next_flags), .q(cur_flags)
  );

  fpcc_pred #(.PRED_W(PRED_W)) u_pred (
    .code(pred_code), .flags(cur_flags), .hit(pred_true), .bad(pred_bad)
  );

  assign cc_n   = cur_flags.n;
  assign cc_z   = cur_flags.z;
  assign cc_inf = cur_flags.inf;
  assign cc_nan = cur_flags.nan;
endmodule

// File: rtl/fpcc_unit_chk.sv
module fpcc_unit_chk #(
  parameter int EXP_W  = 15,
  parameter int MAN_W  = 64,
  parameter int PRED_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              res_valid,
  input logic [EXP_W:0]    res_se,
  input logic [MAN_W-1:0]  res_man,
  input logic [PRED_W-1:0] pred_code,
  input logic              cc_n,
  input logic              cc_z,
  input logic              cc_inf,
  input logic              cc_nan,
  input logic              pred_true,
  input logic              pred_bad,
  input logic              upd_fire,
  input logic              exp_max,
  input logic              frac_zero
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !(cc_n | cc_z | cc_inf | cc_nan)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !res_valid |=> $stable({cc_n, cc_z, cc_inf, cc_nan})); // R2
  AST_SIGN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    upd_fire |=> cc_n == $past(res_se[EXP_W])); // R3
  AST_ZERO_LOADED: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_se[EXP_W-1:0] == '0 && res_man[MAN_W-2:0] == '0) |=> cc_z); // R4
  AST_ZERO_INF_EXCL: assert property (@(posedge clk) disable iff (rst) !(cc_z && cc_inf)); // R5
  AST_INF_NAN_EXCL: assert property (@(posedge clk) disable iff (rst) !(cc_inf && cc_nan)); // R6
  AST_NAN_LOADED: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && exp_max && !frac_zero) |=> cc_nan); // R6
  AST_BAD_IS_FALSE: assert property (@(posedge clk) disable iff (rst) pred_bad |-> !pred_true); // R11
  AST_NEVER_CODE: assert property (@(posedge clk) disable iff (rst)
    (pred_code[3:0] == 4'h0) |-> !pred_true); // R10
  AST_ALWAYS_CODE: assert property (@(posedge clk) disable iff (rst)
    (pred_code[3:0] == 4'hF && !pred_bad) |-> pred_true); // R10
endmodule

bind fpcc_unit fpcc_unit_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .PRED_W(PRED_W)) u_chk (
  .clk(clk), .rst(rst), .res_valid(res_valid), .res_se(res_se), .res_man(res_man),
  .pred_code(pred_code), .cc_n(cc_n), .cc_z(cc_z), .cc_inf(cc_inf), .cc_nan(cc_nan),
  .pred_true(pred_true), .pred_bad(pred_bad), .upd_fire(upd_fire),
  .exp_max(exp_max), .frac_zero(frac_zero)
);

// File: tb/fpcc_unit_test.sv
module fpcc_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        res_valid = 1'b0;
  logic [15:0] res_se = '0;
  logic [63:0] res_man = '0;
  logic [5:0]  pred_code = '0;
  logic cc_n, cc_z, cc_inf, cc_nan, pred_true, pred_bad;
  int vectors = 0;
  int misses = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fpcc_unit uut (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_se(res_se), .res_man(res_man),
    .pred_code(pred_code), .cc_n(cc_n), .cc_z(cc_z), .cc_inf(cc_inf), .cc_nan(cc_nan),
    .pred_true(pred_true), .pred_bad(pred_bad)
  );

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // Relational model: unordered / equal / less / greater.
  function automatic logic model(input logic [5:0] code, input logic n, input logic z, input logic nan);
    logic un, eq, lt, gt, r;
    un = nan;
    eq = z;
    lt = n && !z && !nan;
    gt = !n && !z && !nan;
    case (code[3:0])
      4'h0: r = 0;
      4'h1: r = eq;
      4'h2: r = gt;
      4'h3: r = gt || eq;
      4'h4: r = lt;
      4'h5: r = lt || eq;
      4'h6: r = gt || lt;
      4'h7: r = !un;
      4'h8: r = un;
      4'h9: r = un || eq;
      4'hA: r = un || gt;
      4'hB: r = un || gt || eq;
      4'hC: r = un || lt;
      4'hD: r = un || lt || eq;
      4'hE: r = !eq;
      default: r = 1;
    endcase
    if (code >= 6'h20) r = 0;
    return r;
  endfunction

  task automatic load(input logic [15:0] se, input logic [63:0] man);
    @(negedge clk);
    res_se = se; res_man = man; res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic sweep(input logic n, input logic z, input logic nan);
    for (int c = 0; c < 64; c++) begin
      pred_code = 6'(c);
      #1;
      if (c >= 32) begin
        check("R11 bad flag", pred_bad, 1'b1);
        check("R11 false", pred_true, 1'b0);
      end else begin
        check("R11 supported", pred_bad, 1'b0);
        if (c[3:0] == 4'h0 || c[3:0] == 4'hF)
          check("R10 fixed code", pred_true, model(6'(c), n, z, nan));
        else if (c[3:0] <= 4'h7)
          check("R8 ordered predicate", pred_true, model(6'(c), n, z, nan));
        else
          check("R9 unordered predicate", pred_true, model(6'(c), n, z, nan));
      end
    end
  endtask

  task automatic run_value(input string name, input logic [15:0] se, input logic [63:0] man,
                           input logic n, input logic z, input logic inf, input logic nan);
    load(se, man);
    check({"R3 sign ", name}, cc_n, n);
    check({"R4 zero ", name}, cc_z, z);
    check({"R5 inf ", name}, cc_inf, inf);
    check({"R6 nan ", name}, cc_nan, nan);
    sweep(n, z, nan);
  endtask

  task automatic test_reset();
    check("R1 n", cc_n, 0);
    check("R1 z", cc_z, 0);
    check("R1 inf", cc_inf, 0);
    check("R1 nan", cc_nan, 0);
  endtask

  task automatic test_hold();
    load(16'hFFFF, 64'h0);
    @(negedge clk);
    res_se = 16'h0000; res_man = 64'h0;
    @(negedge clk);
    @(negedge clk);
    check("R2 hold n", cc_n, 1);
    check("R2 hold inf", cc_inf, 1);
    check("R2 hold z", cc_z, 0);
  endtask

  task automatic test_alias();
    load(16'hBFFF, 64'h8000_0000_0000_0000);
    for (int c = 0; c < 16; c++) begin
      logic lo;
      pred_code = 6'(c);
      #1 lo = pred_true;
      pred_code = 6'(c + 16);
      #1 check("R7 alias", pred_true, lo);
    end
  endtask

  task automatic test_rereset();
    load(16'h7FFF, 64'h4000_0000_0000_0000);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    test_reset();
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    test_reset();
    run_value("+1.0", 16'h3FFF, 64'h8000_0000_0000_0000, 0, 0, 0, 0);
    run_value("-2.0", 16'hC000, 64'h8000_0000_0000_0000, 1, 0, 0, 0);
    run_value("+0", 16'h0000, 64'h0, 0, 1, 0, 0);
    run_value("-0", 16'h8000, 64'h0, 1, 1, 0, 0);
    run_value("pseudo0", 16'h0000, 64'h8000_0000_0000_0000, 0, 1, 0, 0);
    run_value("denorm", 16'h0000, 64'h0000_0000_0000_0001, 0, 0, 0, 0);
    run_value("+inf", 16'h7FFF, 64'h8000_0000_0000_0000, 0, 0, 1, 0);
    run_value("-inf", 16'hFFFF, 64'h0, 1, 0, 1, 0);
    run_value("qnan", 16'h7FFF, 64'hC000_0000_0000_0000, 0, 0, 0, 1);
    run_value("-nan lsb", 16'hFFFF, 64'h0000_0000_0000_0001, 1, 0, 0, 1);
    test_hold();
    test_alias();
    test_rereset();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      vectors++;
      misses++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule